// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Sequencing

This block decides when an asynchronous, address-multiplexed DRAM must be refreshed. It does not drive the strobes. It raises a request toward the memory controller, and the controller performs the refresh cycle and answers with an acknowledge. A refresh is counted only when request and acknowledge are both high on the same clock edge.

After reset the scheduler first holds off all traffic for the power-up pause. It then asks for a burst of warm-up refreshes and reports completion on `init_done_o` once every one of them has been acknowledged. From then on a periodic tick spreads refreshes evenly, so that all rows are visited within the retention period. Ticks add to a small, saturating count of owed refreshes. The controller can therefore defer refreshes during a burst of accesses and catch up afterwards. An urgent flag tells it when the debt is full.

For RAS-only refresh the block also presents the next row address. This address advances on every acknowledged refresh and wraps at the row count. The device variant is chosen by the row-address width: 12 bits for a 4096-row part with 64 ms retention, 11 bits for a 2048-row part with 32 ms retention.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `req_o`, `urgent_o` and `init_done_o` are 0, `debt_o` is 0 and `row_o` is 0.
- R2: After reset release, `req_o` stays low for `PAUSE_CYC = CLK_KHZ*PAUSE_US/1000` rising edges and goes high right after edge number `PAUSE_CYC`.
- R3: During warm-up, `req_o` is held high and `debt_o` stays 0. `init_done_o` rises on the edge that completes the `WARM_CNT`-th handshake (default 8) and stays low before that edge.
- R4: The refresh interval is `IVL = floor(CLK_KHZ*RET_MS/2**ROW_BITS)` clocks, where `RET_MS` is 64 for `ROW_BITS`=12 and 32 for `ROW_BITS`=11. The first tick raises the debt to 1 exactly `IVL` edges after `init_done_o` rises, and ticks then repeat every `IVL` edges.
- R5: After initialization, each tick adds 1 to `debt_o` and each handshake subtracts 1. The debt saturates at `DEBT_MAX` (default 8).
- R6: After initialization, `req_o` is high exactly when `debt_o` is nonzero. `urgent_o` is high exactly when `debt_o` equals `DEBT_MAX`.
- R7: An `ack_i` pulse while `req_o` is low has no effect: `row_o` and `debt_o` keep their values.
- R8: A tick and a handshake on the same edge leave `debt_o` unchanged.
- R9: `row_o` advances by 1, modulo `2**ROW_BITS`, on every handshake, warm-up handshakes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_i | input | 1 | Controller has performed the requested refresh |
| req_o | output | 1 | Refresh requested |
| urgent_o | output | 1 | Refresh debt is at its maximum |
| init_done_o | output | 1 | Power-up pause and warm-up refreshes complete |
| debt_o | output | $clog2(DEBT_MAX+1) | Number of refreshes currently owed |
| row_o | output | ROW_BITS | Row address for RAS-only refresh |

## Verification
Several properties are checked on every cycle:
- the request stays silent during the pause;
- the debt stays within its cap and never moves by more than one per cycle;
- urgency implies a request;
- a stray acknowledge leaves the row untouched, and each handshake steps the row by one.

Other behaviour only the scenarios can show. These are the exact pause and interval lengths, the count of warm-up handshakes before completion, saturation after many missed ticks, and the equal tick-and-acknowledge cycle. The row wrap is covered by more than a full pass through all rows, checked by a scoreboard.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_WARM, PH_RUN} phase_e;

  // Retention period in ms for the row-width variant
  function automatic int ret_ms(input int row_bits);
    return (row_bits == 12) ? 64 : 32;
  endfunction
endpackage

// File: rtl/dref_tick.sv
module dref_tick #(
  parameter int LIMIT = 16,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(LIMIT - 1));
  assign tick_o = en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (last)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/dref_debt.sv
module dref_debt #(
  parameter int MAX = 8,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] debt_o,
  output logic         full_o
);
  logic [W-1:0] debt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) debt_q <= '0;
    else if (inc_i && !dec_i && debt_q != W'(MAX)) debt_q <= debt_q + 1'b1;
    else if (dec_i && !inc_i && debt_q != '0)     debt_q <= debt_q - 1'b1;
  end

  assign debt_o = debt_q;
  assign full_o = (debt_q == W'(MAX));

  a_r5_debt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_q <= W'(MAX));
  a_r8_debt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debt_q != $past(debt_q)) |->
      (debt_q == $past(debt_q) + 1'b1) || (debt_q + 1'b1 == $past(debt_q)));
endmodule

// File: rtl/dref_row.sv
module dref_row #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (adv_i) row_o <= row_o + 1'b1;  // wraps at 2**W
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dref_pkg::*;
#(
  parameter int ROW_BITS = 12,
  parameter int CLK_KHZ  = 100000,
  parameter int PAUSE_US = 200,
  parameter int WARM_CNT = 8,
  parameter int DEBT_MAX = 8,
  localparam int DEBT_W  = $clog2(DEBT_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ack_i,
  output logic                req_o,
  output logic                urgent_o,
  output logic                init_done_o,
  output logic [DEBT_W-1:0]   debt_o,
  output logic [ROW_BITS-1:0] row_o
);
  localparam int PAUSE_CYC = CLK_KHZ * PAUSE_US / 1000;
  localparam int IVL       = CLK_KHZ * ret_ms(ROW_BITS) / (1 << ROW_BITS);
  localparam int WW        = $clog2(WARM_CNT + 1);

  phase_e        phase_q;
  logic [WW-1:0] warm_q;
  logic          pause_tick, ivl_tick, hs, run, debt_full;

  assign run = (phase_q == PH_RUN);
  assign hs  = req_o && ack_i;

  dref_tick #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_q == PH_PAUSE), .tick_o(pause_tick));

  dref_tick #(.LIMIT(IVL)) u_ivl (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run), .tick_o(ivl_tick));

  dref_debt #(.MAX(DEBT_MAX)) u_debt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(ivl_tick), .dec_i(hs && run),
    .debt_o(debt_o), .full_o(debt_full));

  dref_row #(.W(ROW_BITS)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(hs), .row_o(row_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PAUSE;
      warm_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_PAUSE: if (pause_tick) phase_q <= PH_WARM;
        PH_WARM: if (hs) begin
          warm_q <= warm_q + 1'b1;
          if (warm_q == WW'(WARM_CNT - 1)) phase_q <= PH_RUN;
        end
        default: ;
      endcase
    end
  end

  assign req_o       = (phase_q == PH_WARM) || (run && debt_o != '0);
  assign urgent_o    = run && debt_full;
  assign init_done_o = run;

  a_r2_quiet_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PAUSE) |-> !req_o);
  a_r3_init_after_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> $past(hs));
  a_r6_urgent_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> req_o);
  a_r7_stray_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o) |=> $stable(row_o));
  a_r9_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> (row_o == $past(row_o) + 1'b1));
endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int RB   = 11;
  localparam int KHZ  = 1000;
  localparam int PC   = KHZ * 200 / 1000;     // 200
  localparam int IV   = KHZ * 32 / (1 << RB); // 15
  localparam int DM   = 8;
  localparam int ROWS = 1 << RB;

  logic clk = 0, rst_n = 0, ack = 0;
  logic req, urg, idone;
  logic [3:0] debt;
  logic [RB-1:0] row;
  int n_chk = 0, n_fail = 0, exp_row = 0;
  int exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  dram_refresh_sched #(.ROW_BITS(RB), .CLK_KHZ(KHZ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ack_i(ack), .req_o(req), .urgent_o(urg),
    .init_done_o(idone), .debt_o(debt), .row_o(row));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // driver: one acknowledged refresh, expected row pushed to scoreboard
  task automatic do_ack();
    @(negedge clk);
    while (!req) @(negedge clk);
    ack = 1;
    exp_row = (exp_row + 1) % ROWS;
    exp_q.push_back(exp_row);
    @(negedge clk);
    ack = 0;
  endtask

  // monitor: compares row after every handshake (R9)
  initial begin
    forever begin
      bit hs;
      @(negedge clk); #1;
      hs = req && ack;
      @(posedge clk); #1;
      if (hs) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected handshake", int'(row), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(row) == e, "R9 row after handshake", int'(row), e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int n, r0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req == 0 && urg == 0 && idone == 0, "R1 reset outputs", int'(req), 0);
    chk(debt == 0 && row == 0, "R1 reset debt/row", int'(debt) + int'(row), 0);
    rst_n = 1;
    #1;
    chk(req == 0 && idone == 0 && debt == 0, "R1 first cycle", int'(req), 0);

    // R2: pause length
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!req && n < 1000);
    chk(n == PC, "R2 pause edges", n, PC);
    chk(idone == 0, "R2 init during pause", int'(idone), 0);

    // R3: warm-up burst
    for (int i = 0; i < 8; i++) begin
      chk(req == 1, "R3 req held in warm-up", int'(req), 1);
      do_ack();
      if (i < 7) begin
        chk(idone == 0, "R3 init early", int'(idone), 0);
        chk(debt == 0, "R3 debt in warm-up", int'(debt), 0);
      end
    end
    chk(idone == 1, "R3 init after 8 acks", int'(idone), 1);

    // R4: first interval
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!req && n < 1000);
    chk(n == IV, "R4 interval edges", n, IV);
    chk(debt == 1, "R4 debt after tick", int'(debt), 1);

    // R5/R6: saturation
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk(debt == DM, "R5 saturated debt", int'(debt), DM);
    chk(urg == 1, "R6 urgent at max", int'(urg), 1);
    do_ack();
    chk(debt == DM - 1, "R5 decrement", int'(debt), DM - 1);
    chk(urg == 0, "R6 urgent clears", int'(urg), 0);
    while (req) do_ack();
    chk(debt == 0 && req == 0, "R6 drained no req", int'(debt), 0);

    // R7: stray ack
    @(negedge clk);
    while (!req) @(negedge clk);
    do_ack();
    r0 = int'(row);
    ack = 1;
    @(negedge clk);
    ack = 0;
    chk(int'(row) == r0, "R7 row unchanged", int'(row), r0);
    chk(debt == 0 && req == 0, "R7 debt unchanged", int'(debt), 0);

    // R8: tick and ack on the same edge
    @(negedge clk);
    while (!req) @(negedge clk);
    repeat (14) @(negedge clk);
    chk(debt == 1, "R8 debt before", int'(debt), 1);
    ack = 1;
    exp_row = (exp_row + 1) % ROWS;
    exp_q.push_back(exp_row);
    @(negedge clk);
    ack = 0;
    chk(debt == 1, "R8 debt after coincident tick/ack", int'(debt), 1);

    // R9: full pass with wrap
    repeat (ROWS + 12) do_ack();
    @(negedge clk);
    chk(int'(row) == exp_row, "R9 row after wrap", int'(row), exp_row);
    chk(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule